// File: doc/BRIEF.md
# Circular Acquisition Memory Address Sequencer

This block sequences the write addresses of a circular sample memory while an acquisition runs, and then hands the memory to a host processor. On the acquisition side, every save strobe stores one sample byte at the current address. The address counter then steps by one and wraps from the top of the record back to zero, so the record always holds the newest samples.

When the acquisition-end request arrives, three things happen on the same edge. The block latches the address of the last byte it stored into a record-end register. It gates off further saves. It switches the memory to host control and raises a done flag. The host must wait for done before it touches the memory.

Under host control, the address counter becomes a plain load register that takes the host address on every clock. A host read strobe then moves the byte at that address onto the host data output. A decoded register select puts the record-end value onto the same output. Because the counter wraps, the oldest byte sits one place after the record end, and the host rebuilds time order from there. A start pulse clears done, zeroes the counter and returns the memory to the acquisition side.

Top module: `acq_addr_seq`

## Requirements
- R1: While reset is low and just after it is released, `done_o` is 0, `mem_addr_o` is 0 and `host_data_o` is 0, with the block on the acquisition side.
- R2: On the acquisition side, with no start, a clock edge with `save_i` high writes `sample_i` at `mem_addr_o`. It then advances `mem_addr_o` by one, wrapping from 2**ADDR_W-1 to 0.
- R3: On the acquisition side, with no start, a clock edge with `acq_end_i` high sets `done_o` after that edge. On the same edge, the record end takes the address of the last stored byte. That is the current address if `save_i` is also high on that edge, and the current address minus one (modulo the record length) otherwise.
- R4: While `done_o` is 1, `save_i` and `acq_end_i` are ignored: no memory byte changes, the record end is unchanged and `done_o` stays 1.
- R5: While `done_o` is 1, `mem_addr_o` equals the `host_addr_i` value sampled at the previous clock edge.
- R6: While `done_o` is 1, a clock edge with `host_rd_i` high loads the byte at `mem_addr_o`. With `host_reg_sel_i` low, `host_data_o` shows that byte, zero-extended, after the edge.
- R7: With `host_reg_sel_i` high, `host_data_o` shows the record end, zero-extended, in the same cycle.
- R8: While `done_o` is 0, `host_rd_i` is ignored and the read value on `host_data_o` does not change.
- R9: A clock edge with `start_i` high clears `done_o` and sets `mem_addr_o` to 0. It takes priority over `acq_end_i` and `save_i` on the same edge.
- R10: After a record that has wrapped, reading the record length of bytes starting one address after the record end (modulo the length) returns the samples in the order they were saved, oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a new acquisition |
| save_i | input | 1 | Save strobe for one sample |
| sample_i | input | DATA_W | Sample byte to store |
| acq_end_i | input | 1 | Acquisition complete request |
| host_addr_i | input | ADDR_W | Host memory address |
| host_rd_i | input | 1 | Host read strobe |
| host_reg_sel_i | input | 1 | Selects the record end onto the host data output |
| host_data_o | output | BUS_W | Host data output |
| done_o | output | 1 | Acquisition complete, host owns memory |
| mem_addr_o | output | ADDR_W | Current memory address |

## Verification
If the counter fails to step, or steps on the wrong side, `mem_addr_o` differs from the model on the very next clock. A wrong wrap shows after the 1024th save. A record end latched one place off shows up in two ways. The register select reads a wrong value in the cycle the host asks for it. The chronological read-back also returns a sequence shifted by one byte. A save that leaks through in host mode corrupts a stored byte, and this appears only when the host reads that address, two clocks after it presents the address.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
   typedef enum logic {
      SIDE_ACQ  = 1'b0,
      SIDE_HOST = 1'b1
   } side_t;
endpackage

// File: rtl/acq_addr_counter.sv
module acq_addr_counter #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              inc_i,
   output logic [ADDR_W-1:0] cnt_o
);
   logic [ADDR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/acq_mode_ctrl.sv
module acq_mode_ctrl
   import acq_seq_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              save_i,
   input  logic              acq_end_i,
   input  logic [ADDR_W-1:0] cnt_i,
   output side_t             side_o,
   output logic              save_en_o,
   output logic              load_o,
   output logic [ADDR_W-1:0] rec_end_o
);
   side_t             side_q;
   logic [ADDR_W-1:0] rec_end_q;
   logic [ADDR_W-1:0] last_addr;

   assign last_addr = save_i ? cnt_i : cnt_i - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         side_q    <= SIDE_ACQ;
         rec_end_q <= '0;
      end else if (start_i) begin
         side_q    <= SIDE_ACQ;
      end else if (side_q == SIDE_ACQ && acq_end_i) begin
         side_q    <= SIDE_HOST;
         rec_end_q <= last_addr;
      end
   end

   assign side_o    = side_q;
   assign save_en_o = save_i && !start_i && (side_q == SIDE_ACQ);
   assign load_o    = (side_q == SIDE_HOST);
   assign rec_end_o = rec_end_q;
endmodule

// File: rtl/acq_sample_ram.sv
module acq_sample_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (we_i) mem[addr_i] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    rd_q <= '0;
      else if (re_i) rd_q <= mem[addr_i];
   end

   assign rdata_o = rd_q;
endmodule

// File: rtl/acq_addr_seq.sv
module acq_addr_seq
   import acq_seq_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8,
   parameter int BUS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              save_i,
   input  logic [DATA_W-1:0] sample_i,
   input  logic              acq_end_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   input  logic              host_rd_i,
   input  logic              host_reg_sel_i,
   output logic [BUS_W-1:0]  host_data_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] mem_addr_o
);
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (BUS_W < ADDR_W || BUS_W < DATA_W) begin : g_bad_bus
      $error("BUS_W narrower than address or data");
   end

   side_t             side;
   logic              save_en;
   logic              load;
   logic              rd_en;
   logic [ADDR_W-1:0] cnt;
   logic [ADDR_W-1:0] rec_end;
   logic [DATA_W-1:0] rd_data;
   logic [BUS_W-1:0]  rec_ext;
   logic [BUS_W-1:0]  rd_ext;

   acq_mode_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .save_i    (save_i),
      .acq_end_i (acq_end_i),
      .cnt_i     (cnt),
      .side_o    (side),
      .save_en_o (save_en),
      .load_o    (load),
      .rec_end_o (rec_end)
   );

   acq_addr_counter #(.ADDR_W(ADDR_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (start_i),
      .load_i     (load),
      .load_val_i (host_addr_i),
      .inc_i      (save_en),
      .cnt_o      (cnt)
   );

   assign rd_en = host_rd_i && (side == SIDE_HOST);

   acq_sample_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (save_en),
      .re_i    (rd_en),
      .addr_i  (cnt),
      .wdata_i (sample_i),
      .rdata_o (rd_data)
   );

   if (BUS_W > ADDR_W) begin : g_rec_pad
      assign rec_ext = {{(BUS_W-ADDR_W){1'b0}}, rec_end};
   end else begin : g_rec_flat
      assign rec_ext = rec_end;
   end

   if (BUS_W > DATA_W) begin : g_rd_pad
      assign rd_ext = {{(BUS_W-DATA_W){1'b0}}, rd_data};
   end else begin : g_rd_flat
      assign rd_ext = rd_data;
   end

   assign host_data_o = host_reg_sel_i ? rec_ext : rd_ext;
   assign done_o      = (side == SIDE_HOST);
   assign mem_addr_o  = cnt;
endmodule

// File: rtl/acq_addr_seq_chk.sv
module acq_addr_seq_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              save_i,
   input logic              acq_end_i,
   input logic              done_o,
   input logic [ADDR_W-1:0] host_addr_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [ADDR_W-1:0] rec_end,
   input logic [DATA_W-1:0] rd_data
);
   // R2
   adv_on_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_o && save_i && !start_i) |=> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

   // R3
   done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_o && acq_end_i && !start_i) |=> done_o);

   // R9
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && mem_addr_o == '0));

   // R4
   host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(rec_end)));

   // R5
   addr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (mem_addr_o == $past(host_addr_i)));

   // R8
   no_early_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |=> $stable(rd_data));
endmodule

bind acq_addr_seq acq_addr_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .save_i      (save_i),
   .acq_end_i   (acq_end_i),
   .done_o      (done_o),
   .host_addr_i (host_addr_i),
   .mem_addr_o  (mem_addr_o),
   .rec_end     (rec_end),
   .rd_data     (rd_data)
);

// File: tb/acq_addr_seq_test.sv
module acq_addr_seq_test;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int BW = 16;
   localparam int LEN = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          save = 1'b0;
   logic [DW-1:0] sample = '0;
   logic          acq_end = 1'b0;
   logic [AW-1:0] haddr = '0;
   logic          hrd = 1'b0;
   logic          hsel = 1'b0;
   logic [BW-1:0] hdata;
   logic          done;
   logic [AW-1:0] maddr;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   acq_addr_seq #(.ADDR_W(AW), .DATA_W(DW), .BUS_W(BW)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start),
      .save_i         (save),
      .sample_i       (sample),
      .acq_end_i      (acq_end),
      .host_addr_i    (haddr),
      .host_rd_i      (hrd),
      .host_reg_sel_i (hsel),
      .host_data_o    (hdata),
      .done_o         (done),
      .mem_addr_o     (maddr)
   );

   // behavioural reference model
   int  m_mem [LEN];
   int  m_addr = 0;
   int  m_rec = 0;
   int  m_rd = 0;
   bit  m_done = 1'b0;

   always @(posedge clk) begin
      int n_addr, n_rec, n_rd;
      bit n_done;
      n_addr = m_addr; n_rec = m_rec; n_rd = m_rd; n_done = m_done;
      if (!rst_n) begin
         n_addr = 0; n_rec = 0; n_rd = 0; n_done = 1'b0;
      end else begin
         if (m_done && hrd) n_rd = m_mem[m_addr];
         if (start) begin
            n_done = 1'b0; n_addr = 0;
         end else if (!m_done) begin
            if (save) begin
               m_mem[m_addr] = int'(sample);
               n_addr = (m_addr + 1) % LEN;
            end
            if (acq_end) begin
               n_done = 1'b1;
               n_rec = save ? m_addr : (m_addr + LEN - 1) % LEN;
            end
         end else begin
            n_addr = int'(haddr);
         end
      end
      m_addr = n_addr; m_rec = n_rec; m_rd = n_rd; m_done = n_done;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // compare against the model every cycle, away from both edges
   always begin
      @(posedge clk);
      #2;
      if (rst_n && !finished) begin
         chk("R3 done", int'(done), int'(m_done));
         chk("R2 address", int'(maddr), m_addr);
         chk("R6 host data", int'(hdata), hsel ? m_rec : m_rd);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic int smp(input int i);
      return (i * 37 + 11) & 255;
   endfunction

   task automatic host_read(input int a);
      haddr = AW'(a);
      hrd = 1'b1;
      @(negedge clk);
      @(negedge clk);
      hrd = 1'b0;
      #1;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 done", int'(done), 0);
      chk("R1 address", int'(maddr), 0);
      chk("R1 data", int'(hdata), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 after release", int'(done), 0);

      // R8 read strobe before done has no effect
      hrd = 1'b1;
      haddr = AW'(5);
      repeat (2) @(negedge clk);
      hrd = 1'b0;
      #1;
      chk("R8 early read", int'(hdata), 0);
      chk("R8 address unchanged", int'(maddr), 0);

      // R2 fill with wrap, last save coincides with end request (R3)
      for (int i = 0; i < 1500; i++) begin
         save = 1'b1;
         sample = DW'(smp(i));
         acq_end = (i == 1499);
         @(negedge clk);
         if (i == LEN - 1) chk("R2 wrap to zero", int'(maddr), 0);
      end
      save = 1'b0;
      acq_end = 1'b0;
      #1;
      chk("R3 done raised", int'(done), 1);
      hsel = 1'b1;
      #1;
      chk("R7 record end", int'(hdata), 1499 % LEN);
      chk("R3 record end with same-edge save", int'(hdata), 475);
      hsel = 1'b0;

      // R4 saves and end requests ignored in host mode
      haddr = AW'(475);
      @(negedge clk);
      save = 1'b1;
      sample = 8'hFF;
      acq_end = 1'b1;
      @(negedge clk);
      save = 1'b0;
      acq_end = 1'b0;
      #1;
      chk("R4 done held", int'(done), 1);
      hsel = 1'b1;
      #1;
      chk("R4 record end held", int'(hdata), 475);
      hsel = 1'b0;
      host_read(475);
      chk("R4 byte not overwritten", int'(hdata), smp(1499));

      // R5 address pass-through
      haddr = AW'(123);
      @(negedge clk);
      #1;
      chk("R5 host address", int'(maddr), 123);

      // R10 chronological read-back from the record end onward
      for (int k = 0; k < LEN; k++) begin
         host_read((475 + 1 + k) % LEN);
         chk("R10 time order", int'(hdata), smp(476 + k));
      end

      // R9 start wins over a same-edge end request
      start = 1'b1;
      acq_end = 1'b1;
      @(negedge clk);
      start = 1'b0;
      acq_end = 1'b0;
      #1;
      chk("R9 done cleared", int'(done), 0);
      chk("R9 address zero", int'(maddr), 0);
      @(negedge clk);
      #1;
      chk("R9 still acquiring", int'(done), 0);

      // R3 end with no saves: record end wraps below zero
      acq_end = 1'b1;
      @(negedge clk);
      acq_end = 1'b0;
      #1;
      chk("R3 empty record done", int'(done), 1);
      hsel = 1'b1;
      #1;
      chk("R3 empty record end", int'(hdata), LEN - 1);
      hsel = 1'b0;

      // short record, no wrap
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 10; i++) begin
         save = 1'b1;
         sample = DW'(smp(2000 + i));
         @(negedge clk);
      end
      save = 1'b0;
      #1;
      chk("R2 short count", int'(maddr), 10);
      acq_end = 1'b1;
      @(negedge clk);
      acq_end = 1'b0;
      hsel = 1'b1;
      #1;
      chk("R3 short record end", int'(hdata), 9);
      hsel = 1'b0;
      host_read(0);
      chk("R6 first byte", int'(hdata), smp(2000));
      host_read(9);
      chk("R6 last byte", int'(hdata), smp(2009));

      @(negedge clk);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule